// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares a reference strobe train with a divided feedback strobe train and drives the pump-up and pump-down controls of a charge pump. Both inputs are single-cycle strobes that mark rising edges, sampled on a faster system clock, so only edge timing reaches the comparison and the duty cycle of the divided signal plays no part. Each input sets its own sticky flag. Once both flags are set, the pair clears after a programmable overlap that stands in for the delay of a reset path.

The block also returns a signed two-bit phase word equal to the up flag minus the down flag. Averaged over one reference period, this word is proportional to the phase difference. Because repeated edges on one side keep that side's flag set, the block also detects frequency. A lock indicator counts consecutive reference periods in which neither flag was high alone for longer than the overlap window.

Top module: `pfd_top`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears `up`, `dn` and `locked`, and `phase` reads 0.
- R2: When the flags are not both high, a `ref_stb` sampled at an edge sets `up` after that edge, and an `fb_stb` sets `dn` after that edge. A flag that is already set stays set when its strobe repeats.
- R3: `phase` is `up` minus `dn` in two's complement: 2'b01 means +1, 2'b00 means 0 and 2'b11 means -1. The code 2'b10 never appears.
- R4: Once `up` and `dn` are both high, they stay high together for exactly K cycles and then clear at the same edge. K is `ovl_len`, and a value of 0 is treated as 1.
- R5: Strobes sampled while `up` and `dn` are both high are ignored and leave both flags clear once the overlap ends.
- R6: Strobes on both inputs in the same cycle raise `up` and `dn` together, with no cycle of +1 or -1 phase, and then clear them after K cycles.
- R7: A reference strobe that leads the feedback strobe by d cycles gives `phase` = +1 for exactly d cycles. A lag of d cycles gives -1 for exactly d cycles.
- R8: When reference strobes come more often than feedback strobes, `phase` is +1 for more cycles than it is -1. The mirror case reverses the sign.
- R9: A reference period is good when no single-flag interval in it lasts longer than K cycles. `locked` changes only at a sampled `ref_stb`. It rises at the strobe that ends the T-th consecutive good period, where T is `lock_len` and 0 is treated as 1. It falls at the strobe that ends a bad period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 1 | Reference rising-edge strobe |
| fb_stb | input | 1 | Divided feedback rising-edge strobe |
| ovl_len | input | OVL_W | Overlap length K in cycles (0 acts as 1) |
| lock_len | input | LOCK_W | Good periods T needed for lock (0 acts as 1) |
| up | output | 1 | Pump-up control |
| dn | output | 1 | Pump-down control |
| phase | output | 2 | Signed phase word, up minus down |
| locked | output | 1 | Lock indicator |

## Verification
A stuck or miscounted overlap counter shows up at the ports within K+1 cycles of the first coincidence: both flags stay high too long or clear too early. A flag that sets wrongly, or fails to ignore strobes during the overlap, makes `phase` differ from a cycle-level reference model by the next edge. It also changes the measured +1 and -1 run lengths of a lead or lag pair. An error in the lock bookkeeping stays hidden until a reference strobe ends a period, and it then shows as `locked` rising one period early or late, or failing to drop after a wide pulse.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef logic signed [1:0] phase_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    localparam phase_t PH_LEAD = 2'sb01;
    localparam phase_t PH_IDLE = 2'sb00;
    localparam phase_t PH_LAG  = 2'sb11;

    function automatic phase_t pump_to_phase(input pump_t p);
        phase_t a, b;
        a = $signed({1'b0, p.up});
        b = $signed({1'b0, p.dn});
        return phase_t'(a - b);
    endfunction

    function automatic logic one_sided(input pump_t p);
        return p.up ^ p.dn;
    endfunction

    function automatic logic both_set(input pump_t p);
        return p.up & p.dn;
    endfunction

endpackage

// File: rtl/pfd_flags.sv
module pfd_flags
    import pfd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_stb,
    input  logic             fb_stb,
    input  logic [CNT_W-1:0] ovl_len,
    output pump_t            pump
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] win;
    logic [CNT_W-1:0] cnt;
    logic             both;

    assign win  = (ovl_len == '0) ? ONE : ovl_len;
    assign both = both_set(pump);

    always_ff @(posedge clk) begin
        if (rst) begin
            pump <= '0;
            cnt  <= '0;
        end else if (both) begin
            if (cnt == win - ONE) begin
                pump <= '0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
        end else begin
            cnt <= '0;
            if (ref_stb) pump.up <= 1'b1;
            if (fb_stb)  pump.dn <= 1'b1;
        end
    end

    // R2: a strobe outside the overlap sets its flag after the edge
    assert_ref_sets_up_R2: assert property (@(posedge clk) disable iff (rst)
        (ref_stb && !both) |=> pump.up);
    assert_fb_sets_dn_R2: assert property (@(posedge clk) disable iff (rst)
        (fb_stb && !both) |=> pump.dn);

    // R4: leaving the overlap clears both flags together
    assert_clear_together_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(both) && !both) |-> (!pump.up && !pump.dn));

    // R4: the overlap counter stays inside its window
    assert_overlap_bound_R4: assert property (@(posedge clk) disable iff (rst)
        both |-> (cnt < win));

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
    import pfd_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int LOCK_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_stb,
    input  pump_t             pump,
    input  logic [CNT_W-1:0]  ovl_len,
    input  logic [LOCK_W-1:0] lock_len,
    output logic              locked
);

    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);
    localparam logic [LOCK_W-1:0] L_ONE = LOCK_W'(1);
    localparam logic [CNT_W-1:0]  C_MAX = '1;

    logic [CNT_W-1:0]  win;
    logic [CNT_W-1:0]  run;
    logic [LOCK_W-1:0] target;
    logic [LOCK_W-1:0] good;
    logic [LOCK_W-1:0] good_next;
    logic              bad;
    logic              bad_now;
    logic              single;

    assign win    = (ovl_len == '0) ? C_ONE : ovl_len;
    assign target = (lock_len == '0) ? L_ONE : lock_len;
    assign single = one_sided(pump);

    always_comb begin
        bad_now = bad | (single && (run >= win));
        if (bad_now)            good_next = '0;
        else if (good < target) good_next = good + L_ONE;
        else                    good_next = good;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= '0;
            bad    <= 1'b0;
            good   <= '0;
            locked <= 1'b0;
        end else begin
            if (!single)           run <= '0;
            else if (run != C_MAX) run <= run + C_ONE;
            if (ref_stb) begin
                good   <= good_next;
                bad    <= 1'b0;
                locked <= (good_next >= target);
            end else begin
                bad <= bad_now;
            end
        end
    end

    // R9: the lock flag moves only at a sampled reference strobe
    assert_lock_rise_on_ref_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ref_stb));
    assert_lock_fall_on_ref_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(ref_stb));

endmodule

// File: rtl/pfd_top.sv
module pfd_top
    import pfd_pkg::*;
#(
    parameter int OVL_W  = 4,
    parameter int LOCK_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_stb,
    input  logic              fb_stb,
    input  logic [OVL_W-1:0]  ovl_len,
    input  logic [LOCK_W-1:0] lock_len,
    output logic              up,
    output logic              dn,
    output logic signed [1:0] phase,
    output logic              locked
);

    pump_t pump;

    pfd_flags #(.CNT_W(OVL_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .ref_stb (ref_stb),
        .fb_stb  (fb_stb),
        .ovl_len (ovl_len),
        .pump    (pump)
    );

    pfd_lock #(.CNT_W(OVL_W), .LOCK_W(LOCK_W)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .ref_stb  (ref_stb),
        .pump     (pump),
        .ovl_len  (ovl_len),
        .lock_len (lock_len),
        .locked   (locked)
    );

    assign up    = pump.up;
    assign dn    = pump.dn;
    assign phase = pump_to_phase(pump);

    // R3: the unused code never shows on the phase word
    assert_phase_code_R3: assert property (@(posedge clk) disable iff (rst)
        phase != 2'b10);

    // R6: coincident strobes from idle raise both flags at once
    assert_coincident_R6: assert property (@(posedge clk) disable iff (rst)
        (ref_stb && fb_stb && !up && !dn) |=> (up && dn));

    // R1: the edge after reset leaves everything idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!up && !dn && !locked));

endmodule

// File: tb/pfd_top_bench.sv
module pfd_top_bench;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ref_stb = 1'b0;
    logic              fb_stb = 1'b0;
    logic [3:0]        ovl_len = 4'd1;
    logic [5:0]        lock_len = 6'd1;
    logic              up, dn, locked;
    logic signed [1:0] phase;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfd_top u_pfd_top (
        .clk(clk), .rst(rst), .ref_stb(ref_stb), .fb_stb(fb_stb),
        .ovl_len(ovl_len), .lock_len(lock_len),
        .up(up), .dn(dn), .phase(phase), .locked(locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cycle-level reference model written from the requirements
    bit m_up = 0, m_dn = 0, m_bad = 0, m_lock = 0;
    int m_cnt = 0, m_run = 0, m_good = 0;
    int k_e, t_e, g_n;
    bit one_e, badnow_e;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_up <= 0; m_dn <= 0; m_cnt <= 0; m_run <= 0;
            m_good <= 0; m_bad <= 0; m_lock <= 0;
        end else begin
            k_e = eff(int'(ovl_len));
            t_e = eff(int'(lock_len));
            if (m_up && m_dn) begin
                if (m_cnt == k_e - 1) begin m_up <= 0; m_dn <= 0; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end else begin
                m_cnt <= 0;
                if (ref_stb) m_up <= 1;
                if (fb_stb)  m_dn <= 1;
            end
            one_e = m_up ^ m_dn;
            badnow_e = m_bad || (one_e && m_run >= k_e);
            m_run <= one_e ? m_run + 1 : 0;
            if (ref_stb) begin
                g_n = badnow_e ? 0 : ((m_good < t_e) ? m_good + 1 : m_good);
                m_good <= g_n;
                m_bad <= 0;
                m_lock <= (g_n >= t_e);
            end else begin
                m_bad <= badnow_e;
            end
        end
    end

    bit cmp_en = 0;
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            check(up == m_up, "R2 model up", int'(up), int'(m_up));
            check(dn == m_dn, "R4 model dn", int'(dn), int'(m_dn));
            check(int'(phase) == int'(m_up) - int'(m_dn), "R3 model phase",
                  int'(phase), int'(m_up) - int'(m_dn));
            check(locked == m_lock, "R9 model locked", int'(locked), int'(m_lock));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_stb = 0; fb_stb = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // lead > 0: reference first; lead < 0: feedback first
    task automatic pair_run(input int lead, input bit inject, input string tag);
        int plus = 0, minus = 0, both = 0;
        int a = (lead >= 0) ? 0 : -lead;
        int b = (lead >= 0) ? lead : 0;
        int m = (a > b) ? a : b;
        int k = eff(int'(ovl_len));
        int span = m + k + 4;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            if (up && !dn) plus++;
            if (dn && !up) minus++;
            if (up && dn) both++;
            ref_stb = (i == a) || (inject && i == m + 1);
            fb_stb  = (i == b) || (inject && i == m + 1);
        end
        @(negedge clk);
        ref_stb = 0; fb_stb = 0;
        check(plus == ((lead > 0) ? lead : 0), {tag, " R7 lead cycles"}, plus, (lead > 0) ? lead : 0);
        check(minus == ((lead < 0) ? -lead : 0), {tag, " R7 lag cycles"}, minus, (lead < 0) ? -lead : 0);
        check(both == k, {tag, " R4 overlap cycles"}, both, k);
        if (inject) check(!up && !dn, {tag, " R5 strobes in overlap ignored"}, int'(up) + int'(dn), 0);
        else        check(!up && !dn, {tag, " R4 cleared after overlap"}, int'(up) + int'(dn), 0);
        if (lead == 0) check(plus + minus == 0, {tag, " R6 coincident no single side"}, plus + minus, 0);
    endtask

    task automatic freq_run(input int pr, input int pf, output int plus, output int minus);
        plus = 0; minus = 0;
        for (int i = 0; i < 420; i++) begin
            @(negedge clk);
            if (phase == 2'sb01) plus++;
            if (phase == 2'sb11) minus++;
            ref_stb = (i % pr) == 0;
            fb_stb  = (i % pf) == 3;
        end
        @(negedge clk);
        ref_stb = 0; fb_stb = 0;
    endtask

    initial begin
        int p, q;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!up && !dn && !locked, "R1 reset outputs", int'(up) + int'(dn) + int'(locked), 0);
        check(phase == 2'sb00, "R1 reset phase", int'(phase), 0);
        rst = 1'b0;
        cmp_en = 1'b1;

        // directed phase cases for several overlap lengths, 0 acting as 1
        foreach (ovl_vals[j]) begin
            ovl_len = ovl_vals[j];
            pair_run(3, 0, "lead3");
            pair_run(-4, 0, "lag4");
            pair_run(0, 0, "coincide");
            pair_run(1, 0, "lead1");
            pair_run(2, 1, "inject");
        end

        // lock sequence R9
        ovl_len = 4'd2; lock_len = 6'd4;
        do_reset();
        repeat (3) pair_run(0, 0, "lock");
        check(locked == 1'b0, "R9 not locked after three good periods", int'(locked), 0);
        pair_run(0, 0, "lock");
        check(locked == 1'b1, "R9 locked after four good periods", int'(locked), 1);
        pair_run(5, 0, "wide");
        check(locked == 1'b1, "R9 lock held until period ends", int'(locked), 1);
        pair_run(0, 0, "lock");
        check(locked == 1'b0, "R9 lock dropped after wide pulse", int'(locked), 0);

        // frequency detection R8
        ovl_len = 4'd1;
        do_reset();
        freq_run(5, 8, p, q);
        check(p > q, "R8 faster reference gives positive average", p - q, 1);
        do_reset();
        freq_run(8, 5, p, q);
        check(q > p, "R8 slower reference gives negative average", q - p, 1);

        // constrained random strobes against the model
        for (int r = 0; r < 4; r++) begin
            ovl_len = 4'($urandom_range(0, 5));
            lock_len = 6'($urandom_range(0, 6));
            do_reset();
            for (int i = 0; i < 1500; i++) begin
                @(negedge clk);
                ref_stb = ($urandom_range(0, 5) == 0);
                fb_stb  = ($urandom_range(0, 5) == 0);
            end
            @(negedge clk);
            ref_stb = 0; fb_stb = 0;
        end

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [3:0] ovl_vals [3] = '{4'd0, 4'd1, 4'd3};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule